// File: doc/BRIEF.md
# Watchdog and Interval Timer

An 8-bit up-counting timer that runs either as a periodic interval timer or as a watchdog. Software reaches it through a small synchronous register bus with two locations: a control/status byte and the counter byte. The counter advances on a tick taken from one of sixteen prescaler taps. Eight taps divide a main-clock enable and eight divide a sub-clock enable. Both enables are single-cycle qualifiers in the block's own clock domain.

When the counter wraps from 0xFF to 0x00, an overflow flag is set. In interval mode this raises a level interrupt. In watchdog mode the overflow either emits a one-cycle non-maskable interrupt pulse or starts an internal reset. The internal reset drives an active-low reset pin and returns every register of the block to its reset value. Software can only clear the flag by reading the status byte while the flag is set and then writing a 0 into the flag position.

Control/status byte (address 0): bit 7 overflow flag, bit 6 mode (1 = watchdog), bit 5 run enable, bit 4 tick source (1 = sub-clock), bit 3 overflow action in watchdog mode (1 = internal reset, 0 = NMI), bits 2:0 tap select. The counter sits at address 1.

Top module: `wdt_timer`

## Requirements
- R1: After reset, the control/status byte and the counter both read 0x00, the reset pin is high, and no interrupt is asserted.
- R2: When the run bit is 1, a write to address 1 loads the counter, and reading address 1 returns it. A counter write wins over a tick in the same cycle.
- R3: When the run bit is 0, the counter holds 0x00 and ignores writes. Writing 0 to the run bit also clears the overflow flag.
- R4: Writing 1 to bit 7 never sets the overflow flag.
- R5: Writing 0 to bit 7 clears the flag only if the status byte was read while the flag was 1. Without such a read, the write leaves the flag set.
- R6: Any write to the status byte consumes the read qualifier, so a later clear needs a fresh read.
- R7: A tick with the counter at 0xFF wraps it to 0x00 and sets the overflow flag. The flag then reads as bit 7 of address 0.
- R8: In interval mode (bit 6 = 0), the interval interrupt output is high exactly while the overflow flag is set.
- R9: In watchdog mode with bit 3 = 0, an overflow gives a one-cycle NMI pulse and no interval interrupt.
- R10: In watchdog mode with bit 3 = 1, an overflow drives the reset pin low for exactly 8 cycles. After that, both registers read 0x00.
- R11: With bit 4 = 0, tap codes 0..7 divide the main enable by 2, 64, 128, 512, 2048, 8192, 32768 and 131072. Each rising transition of the chosen prescaler bit gives one tick.
- R12: With bit 4 = 1, tap codes 0..7 divide the sub enable by 2, 4, 8, 16, 32, 64, 128 and 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| main_ce_i | input | 1 | Main-clock enable feeding the main prescaler |
| sub_ce_i | input | 1 | Sub-clock enable feeding the sub prescaler |
| addr_i | input | 1 | Register select: 0 status, 1 counter |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| ivl_irq_o | output | 1 | Interval interrupt request (level) |
| nmi_o | output | 1 | Watchdog NMI pulse |
| rst_no | output | 1 | Active-low internal reset pin |

## Verification
The bench builds the block with its default parameters: the full divider ladders, an 8-bit counter and an 8-cycle reset pulse. It reaches overflow quickly by loading the counter with 0xFF. It then drives the sub enable by hand, so that exactly one tick occurs at tap code 0 and the counter stays frozen between steps. The divide-by-64 main tap and the divide-by-256 sub tap are measured by counting ticks over whole multiples of their periods. This makes the result independent of the free-running prescaler phase.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef struct packed {
    logic       ovf;
    logic       wd_mode;
    logic       run;
    logic       src_sub;
    logic       rst_sel;
    logic [2:0] tap;
  } csr_t;

  localparam logic ADDR_CSR = 1'b0;
  localparam logic ADDR_CNT = 1'b1;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int         W   = 17,
  parameter int         NT  = 8,
  parameter logic [39:0] EXP = {5'd17, 5'd15, 5'd13, 5'd11, 5'd9, 5'd7, 5'd6, 5'd1}
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    srst_i,
  input  logic                    ce_i,
  input  logic [$clog2(NT)-1:0]   sel_i,
  output logic                    tick_o
);
  logic [W-1:0]  cnt_q;
  logic [NT-1:0] taps;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (srst_i) cnt_q <= '0;
    else if (ce_i)   cnt_q <= cnt_q + 1'b1;
  end

  // tap k rises on the enable that carries the low k bits from 0..01..1 to 1..10..0
  for (genvar i = 0; i < NT; i++) begin : g_tap
    localparam int K = int'(EXP[i*5 +: 5]);
    localparam logic [W-1:0] LOW  = W'((64'd1 << K) - 64'd1);
    localparam logic [W-1:0] HALF = W'((64'd1 << (K - 1)) - 64'd1);
    assign taps[i] = ((cnt_q & LOW) == HALF);
  end

  assign tick_o = ce_i & taps[sel_i];
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic         run_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_evt_o
);
  logic [W-1:0] cnt_q;

  assign ovf_evt_o = run_i & ~wr_i & tick_i & ~srst_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (srst_i || !run_i) cnt_q <= '0;
    else if (wr_i)           cnt_q <= wdata_i;
    else if (tick_i)         cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdt_rstgen.sv
module wdt_rstgen #(
  parameter int N = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o
);
  localparam int CW = $clog2(N + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  left_q <= '0;
    else if (left_q != '0)        left_q <= left_q - 1'b1;
    else if (start_i)             left_q <= CW'(N);
  end

  assign active_o = (left_q != '0);
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int          CNT_W    = 8,
  parameter int          MAIN_W   = 17,
  parameter int          SUB_W    = 8,
  parameter logic [39:0] MAIN_EXP = {5'd17, 5'd15, 5'd13, 5'd11, 5'd9, 5'd7, 5'd6, 5'd1},
  parameter logic [39:0] SUB_EXP  = {5'd8, 5'd7, 5'd6, 5'd5, 5'd4, 5'd3, 5'd2, 5'd1},
  parameter int          RST_CYC  = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       main_ce_i,
  input  logic       sub_ce_i,
  input  logic       addr_i,
  input  logic       we_i,
  input  logic       re_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       ivl_irq_o,
  output logic       nmi_o,
  output logic       rst_no
);
  csr_t         csr_q, wcsr;
  logic         armed_q, nmi_q;
  logic         srst, ovf_evt, tick_main, tick_sub, tick;
  logic [CNT_W-1:0] cnt_q;
  logic         csr_wr, csr_rd, cnt_wr;

  assign wcsr   = csr_t'(wdata_i);
  assign csr_wr = we_i & (addr_i == ADDR_CSR);
  assign csr_rd = re_i & (addr_i == ADDR_CSR);
  assign cnt_wr = we_i & (addr_i == ADDR_CNT);

  wdt_prescaler #(.W(MAIN_W), .NT(8), .EXP(MAIN_EXP)) u_pre_main (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst), .ce_i(main_ce_i),
    .sel_i(csr_q.tap), .tick_o(tick_main)
  );

  wdt_prescaler #(.W(SUB_W), .NT(8), .EXP(SUB_EXP)) u_pre_sub (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst), .ce_i(sub_ce_i),
    .sel_i(csr_q.tap), .tick_o(tick_sub)
  );

  assign tick = csr_q.src_sub ? tick_sub : tick_main;

  wdt_count #(.W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst), .run_i(csr_q.run),
    .wr_i(cnt_wr), .wdata_i(wdata_i[CNT_W-1:0]), .tick_i(tick),
    .cnt_o(cnt_q), .ovf_evt_o(ovf_evt)
  );

  wdt_rstgen #(.N(RST_CYC)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(ovf_evt & csr_q.wd_mode & csr_q.rst_sel),
    .active_o(srst)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_q   <= '0;
      armed_q <= 1'b0;
      nmi_q   <= 1'b0;
    end else if (srst) begin
      csr_q   <= '0;
      armed_q <= 1'b0;
      nmi_q   <= 1'b0;
    end else begin
      nmi_q <= ovf_evt & csr_q.wd_mode & ~csr_q.rst_sel;
      if (csr_wr) begin
        csr_q.wd_mode <= wcsr.wd_mode;
        csr_q.run     <= wcsr.run;
        csr_q.src_sub <= wcsr.src_sub;
        csr_q.rst_sel <= wcsr.rst_sel;
        csr_q.tap     <= wcsr.tap;
        armed_q       <= 1'b0;
      end else if (csr_rd && csr_q.ovf) begin
        armed_q <= 1'b1;
      end
      // set beats any clear in the same cycle
      if (ovf_evt)                               csr_q.ovf <= 1'b1;
      else if (csr_wr && !wcsr.run)              csr_q.ovf <= 1'b0;
      else if (csr_wr && !wcsr.ovf && armed_q)   csr_q.ovf <= 1'b0;
    end
  end

  assign rdata_o   = (addr_i == ADDR_CNT) ? 8'(cnt_q) : 8'(csr_q);
  assign ivl_irq_o = csr_q.ovf & ~csr_q.wd_mode;
  assign nmi_o     = nmi_q;
  assign rst_no    = ~srst;
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             wd_i,
  input logic             ovf_i,
  input logic             ovf_evt_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             irq_i,
  input logic             nmi_i,
  input logic             rst_n_pin_i
);
  p_cnt_held_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_i == '0);

  p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_i |=> ovf_i);

  p_flag_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_i) |-> $past(ovf_evt_i));

  p_irq_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_evt_i && !wd_i) |=> irq_i);

  p_nmi_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_i |-> ovf_i && wd_i);

  p_rst_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_n_pin_i |=> (cnt_i == '0) && !run_i);
endmodule

bind wdt_timer wdt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(csr_q.run), .wd_i(csr_q.wd_mode),
  .ovf_i(csr_q.ovf), .ovf_evt_i(ovf_evt), .cnt_i(cnt_q), .irq_i(ivl_irq_o),
  .nmi_i(nmi_o), .rst_n_pin_i(rst_no)
);

// File: tb/wdt_timer_tb_top.sv
module wdt_timer_tb_top;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic main_ce_i = 1'b0, sub_ce_i = 1'b0;
  logic addr_i = 1'b0, we_i = 1'b0, re_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic ivl_irq_o, nmi_o, rst_no;

  int n_chk = 0, n_fail = 0;
  int nmi_cnt = 0, rst_low_cnt = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  always #2 clk_i = ~clk_i;

  wdt_timer dut_i (.*);

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: issue read and push expectation
  task automatic rd(logic a, logic [7:0] e, string tag);
    @(negedge clk_i);
    addr_i = a; re_i = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk_i);
    re_i = 1'b0;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic sub_pulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); sub_ce_i = 1'b1;
      @(negedge clk_i); sub_ce_i = 1'b0;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  // monitor: compare read data against scoreboard
  always @(negedge clk_i) begin
    #1;
    if (re_i && exp_q.size() > 0) check(tag_q.pop_front(), rdata_o, exp_q.pop_front());
    if (nmi_o) nmi_cnt++;
    if (!rst_no) rst_low_cnt++;
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(2);
    // R1
    rd(1'b0, 8'h00, "R1 csr");
    rd(1'b1, 8'h00, "R1 cnt");
    check("R1 rst_no", rst_no, 1);
    check("R1 irq", ivl_irq_o, 0);
    // R3 counter ignores writes while stopped
    wr(1'b1, 8'h5A);
    rd(1'b1, 8'h00, "R3 cnt write ignored");
    // R2 enabled, sub source frozen
    wr(1'b0, 8'h30);
    wr(1'b1, 8'hA5);
    rd(1'b1, 8'hA5, "R2 cnt load");
    sub_pulse(2);
    rd(1'b1, 8'hA6, "R12 one tick at div2");
    // R7 overflow
    wr(1'b1, 8'hFF);
    sub_pulse(2);
    idle(1);
    check("R8 irq set", ivl_irq_o, 1);
    // R5 write 0 without read
    wr(1'b0, 8'h30);
    idle(1);
    check("R5 no clear without read", ivl_irq_o, 1);
    rd(1'b1, 8'h00, "R7 cnt wrapped");
    rd(1'b0, 8'hB0, "R7 flag set");
    wr(1'b0, 8'h30);
    idle(1);
    check("R5 cleared", ivl_irq_o, 0);
    rd(1'b0, 8'h30, "R5 csr after clear");
    // R4 write one ignored
    wr(1'b0, 8'hB0);
    rd(1'b0, 8'h30, "R4 no set by write");
    check("R4 irq", ivl_irq_o, 0);
    // R6 qualifier consumed
    wr(1'b1, 8'hFF);
    sub_pulse(2);
    rd(1'b0, 8'hB0, "R6 flag set again");
    wr(1'b0, 8'hB0);
    wr(1'b0, 8'h30);
    rd(1'b0, 8'hB0, "R6 stale qualifier");
    // R3 run=0 clears flag and counter
    wr(1'b0, 8'h10);
    rd(1'b0, 8'h10, "R3 flag cleared");
    rd(1'b1, 8'h00, "R3 cnt zero");
    // R9 NMI
    wr(1'b0, 8'h70);
    wr(1'b1, 8'hFF);
    sub_pulse(2);
    idle(2);
    check("R9 nmi pulses", nmi_cnt, 1);
    check("R9 no irq", ivl_irq_o, 0);
    check("R9 rst_no high", rst_no, 1);
    rd(1'b0, 8'hF0, "R9 flag");
    wr(1'b0, 8'h10);
    // R11 main div 64
    wr(1'b0, 8'h21);
    wr(1'b1, 8'h00);
    @(negedge clk_i); main_ce_i = 1'b1;
    repeat (192) @(negedge clk_i);
    main_ce_i = 1'b0;
    rd(1'b1, 8'h03, "R11 div64 ticks");
    // R12 sub div 256
    wr(1'b0, 8'h37);
    wr(1'b1, 8'h00);
    sub_pulse(512);
    rd(1'b1, 8'h02, "R12 div256 ticks");
    // R10 watchdog reset
    wr(1'b0, 8'h78);
    wr(1'b1, 8'hFF);
    rst_low_cnt = 0;
    sub_pulse(2);
    idle(12);
    check("R10 reset length", rst_low_cnt, 8);
    rd(1'b0, 8'h00, "R10 csr reset");
    rd(1'b1, 8'h00, "R10 cnt reset");
    idle(2);
    check("R2 scoreboard drained", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule